// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Resolver

This combinational unit handles the work around a floating-point multiply that does not involve the significand product. It takes the class, sign and exponent of each of two operands. From these it decides the class and sign of the result and raises the two invalid-operation flags. It also reports where the result value comes from: operand A, operand B, a built-in default NaN, or the mantissa multiplier.

First the unit orders the operands internally. The operand whose class has the higher priority goes to an inner "y" slot and the other goes to "x". After that, each case needs only a check of y, or a check of x. For two ordinary numbers, the unit raises a multiply request and adds the signed exponents.

The unit also contains the one-step post-normaliser for the product. The significand product comes back from the multiplier with two integer bits. When the upper integer bit is set, the significand moves right by one place, the bit that falls off is folded into sticky, and the exponent goes up by one. The multiplier itself and rounding sit outside this block.

Top module: `fmul_special_resolver`

## Requirements
- R1: Class codes on the class ports are 0 number, 1 zero, 2 infinity, 3 quiet NaN and 4 signalling NaN. Source codes on `res_src` are 0 multiplier, 1 operand A, 2 operand B and 3 default NaN.
- R2: If either operand is a NaN, the result carries the NaN operand's class and sign, and `res_src` selects that operand. With two NaNs, a signalling one is chosen over a quiet one. With two NaNs of equal kind, operand B is chosen.
- R3: `flag_snan` is 1 exactly when at least one operand is a signalling NaN.
- R4: Infinity times zero, in either order and with no NaN present, gives a quiet NaN with sign 0 and source 3, and raises `flag_imz`. `flag_imz` is 0 in every other case.
- R5: Infinity times a number or an infinity gives infinity with sign `a_sign ^ b_sign`. The source is the infinite operand, and operand B when both are infinite.
- R6: Zero times a number or zero gives zero with sign `a_sign ^ b_sign`. The source is the zero operand, and operand A when both are zero.
- R7: Number times number gives class number, sign `a_sign ^ b_sign` and source 0, and raises `mul_req`. `mul_req` is 0 for every other class pair.
- R8: `exp_sum` always equals the signed sum `a_exp + b_exp`, one bit wider than the inputs.
- R9: When `prod_sig` has its top bit set, `norm_sig` is `prod_sig` shifted right by one, `norm_sticky` is `sticky_in` OR the bit shifted out, and `norm_exp` is `exp_sum + 1`.
- R10: When the top bit of `prod_sig` is clear, `norm_sig`, `norm_sticky` and `norm_exp` equal `prod_sig`, `sticky_in` and `exp_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_cls | input | 3 | Class code of operand A |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Signed exponent of operand A |
| b_cls | input | 3 | Class code of operand B |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Signed exponent of operand B |
| prod_sig | input | PROD_W | Significand product, two integer bits on top |
| sticky_in | input | 1 | Sticky bit accumulated by the multiplier |
| res_cls | output | 3 | Class code of the result |
| res_sign | output | 1 | Sign of the result |
| res_src | output | 2 | Source of the result value |
| flag_snan | output | 1 | Invalid operation: signalling NaN operand |
| flag_imz | output | 1 | Invalid operation: infinity times zero |
| mul_req | output | 1 | Mantissa multiply is needed |
| exp_sum | output | EXP_W+1 | Signed exponent sum |
| norm_exp | output | EXP_W+1 | Exponent after post-normalisation |
| norm_sig | output | PROD_W | Significand after post-normalisation |
| norm_sticky | output | 1 | Sticky after post-normalisation |

## Verification
The checker watches the input-to-output relations that hold for every input combination:
- a NaN operand always gives a NaN result;
- the signalling flag follows the operand classes;
- the infinity-times-zero flag appears only with a positive default NaN;
- the multiply request goes with a number result and the multiplier source;
- the normalised exponent is either equal to the sum or one above it;
- the normalised significand never keeps its top bit.

Which operand is selected when the classes tie, the exact sign of each special result, and exponent sums at the edges of the signed range can only be shown by the bench's directed class pairs and values.

// File: rtl/fmsr_pkg.sv
package fmsr_pkg;

   typedef enum logic [2:0] {
      CLS_NUM  = 3'd0,
      CLS_ZERO = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } fp_cls_t;

   typedef enum logic [1:0] {
      SRC_MUL  = 2'd0,
      SRC_A    = 2'd1,
      SRC_B    = 2'd2,
      SRC_DFLT = 2'd3
   } res_src_t;

   // Ordering weight: a heavier class goes to the y slot.
   // Zero is the lightest, so an x-side zero test suffices.
   function automatic logic [2:0] cls_weight(input logic [2:0] c);
      case (c)
         CLS_SNAN: cls_weight = 3'd4;
         CLS_QNAN: cls_weight = 3'd3;
         CLS_INF:  cls_weight = 3'd2;
         CLS_NUM:  cls_weight = 3'd1;
         default:  cls_weight = 3'd0;
      endcase
   endfunction

   function automatic logic is_nan(input logic [2:0] c);
      is_nan = (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction

endpackage

// File: rtl/fmsr_order.sv
module fmsr_order
   import fmsr_pkg::*;
(
   input  logic [2:0] a_cls,
   input  logic       a_sign,
   input  logic [2:0] b_cls,
   input  logic       b_sign,
   output logic [2:0] x_cls,
   output logic       x_sign,
   output logic [2:0] y_cls,
   output logic       y_sign,
   output logic       swapped
);

   // Swap only on a strictly heavier A; ties keep A in x.
   assign swapped = cls_weight(a_cls) > cls_weight(b_cls);

   always_comb begin
      if (swapped) begin
         x_cls  = b_cls;
         x_sign = b_sign;
         y_cls  = a_cls;
         y_sign = a_sign;
      end else begin
         x_cls  = a_cls;
         x_sign = a_sign;
         y_cls  = b_cls;
         y_sign = b_sign;
      end
   end

endmodule

// File: rtl/fmsr_decide.sv
module fmsr_decide
   import fmsr_pkg::*;
(
   input  logic [2:0] x_cls,
   input  logic       x_sign,
   input  logic [2:0] y_cls,
   input  logic       y_sign,
   input  logic       swapped,
   output logic [2:0] res_cls,
   output logic       res_sign,
   output logic [1:0] res_src,
   output logic       flag_snan,
   output logic       flag_imz,
   output logic       mul_req
);

   logic [1:0] src_x;
   logic [1:0] src_y;
   logic       sign_xor;

   assign src_x    = swapped ? SRC_B : SRC_A;
   assign src_y    = swapped ? SRC_A : SRC_B;
   assign sign_xor = x_sign ^ y_sign;

   always_comb begin
      res_cls   = CLS_NUM;
      res_sign  = sign_xor;
      res_src   = SRC_MUL;
      flag_snan = (x_cls == CLS_SNAN) || (y_cls == CLS_SNAN);
      flag_imz  = 1'b0;
      mul_req   = 1'b0;
      if (is_nan(y_cls)) begin
         res_cls  = y_cls;
         res_sign = y_sign;
         res_src  = src_y;
      end else if (y_cls == CLS_INF) begin
         if (x_cls == CLS_ZERO) begin
            res_cls  = CLS_QNAN;
            res_sign = 1'b0;
            res_src  = SRC_DFLT;
            flag_imz = 1'b1;
         end else begin
            res_cls  = CLS_INF;
            res_src  = src_y;
         end
      end else if (x_cls == CLS_ZERO) begin
         res_cls = CLS_ZERO;
         res_src = src_x;
      end else begin
         mul_req = 1'b1;
      end
   end

endmodule

// File: rtl/fmsr_expnorm.sv
module fmsr_expnorm #(
   parameter int EXP_W   = 11,
   parameter int PROD_W  = 48,
   parameter bit NORM_EN = 1'b1
) (
   input  logic signed [EXP_W-1:0] a_exp,
   input  logic signed [EXP_W-1:0] b_exp,
   input  logic        [PROD_W-1:0] prod_sig,
   input  logic                     sticky_in,
   output logic signed [EXP_W:0]    exp_sum,
   output logic signed [EXP_W:0]    norm_exp,
   output logic        [PROD_W-1:0] norm_sig,
   output logic                     norm_sticky
);

   localparam int SUM_W = EXP_W + 1;

   logic signed [SUM_W-1:0] a_wide;
   logic signed [SUM_W-1:0] b_wide;

   assign a_wide  = SUM_W'(a_exp);
   assign b_wide  = SUM_W'(b_exp);
   assign exp_sum = a_wide + b_wide;

   generate
      if (NORM_EN) begin : g_norm
         logic carry_top;
         assign carry_top   = prod_sig[PROD_W-1];
         assign norm_sig    = carry_top ? {1'b0, prod_sig[PROD_W-1:1]} : prod_sig;
         assign norm_sticky = sticky_in | (carry_top & prod_sig[0]);
         assign norm_exp    = exp_sum + SUM_W'(carry_top);
      end else begin : g_pass
         assign norm_sig    = prod_sig;
         assign norm_sticky = sticky_in;
         assign norm_exp    = exp_sum;
      end
   endgenerate

endmodule

// File: rtl/fmul_special_resolver.sv
module fmul_special_resolver
   import fmsr_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int PROD_W  = 48,
   parameter bit NORM_EN = 1'b1
) (
   input  logic [2:0]              a_cls,
   input  logic                    a_sign,
   input  logic signed [EXP_W-1:0] a_exp,
   input  logic [2:0]              b_cls,
   input  logic                    b_sign,
   input  logic signed [EXP_W-1:0] b_exp,
   input  logic [PROD_W-1:0]       prod_sig,
   input  logic                    sticky_in,
   output logic [2:0]              res_cls,
   output logic                    res_sign,
   output logic [1:0]              res_src,
   output logic                    flag_snan,
   output logic                    flag_imz,
   output logic                    mul_req,
   output logic signed [EXP_W:0]   exp_sum,
   output logic signed [EXP_W:0]   norm_exp,
   output logic [PROD_W-1:0]       norm_sig,
   output logic                    norm_sticky
);

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fmul_special_resolver: EXP_W must be at least 2");
      end
      if (PROD_W < 4) begin : g_bad_prod
         $error("fmul_special_resolver: PROD_W must be at least 4");
      end
   endgenerate

   logic [2:0] x_cls;
   logic       x_sign;
   logic [2:0] y_cls;
   logic       y_sign;
   logic       swapped;

   fmsr_order u_order (
      .a_cls   (a_cls),
      .a_sign  (a_sign),
      .b_cls   (b_cls),
      .b_sign  (b_sign),
      .x_cls   (x_cls),
      .x_sign  (x_sign),
      .y_cls   (y_cls),
      .y_sign  (y_sign),
      .swapped (swapped)
   );

   fmsr_decide u_decide (
      .x_cls     (x_cls),
      .x_sign    (x_sign),
      .y_cls     (y_cls),
      .y_sign    (y_sign),
      .swapped   (swapped),
      .res_cls   (res_cls),
      .res_sign  (res_sign),
      .res_src   (res_src),
      .flag_snan (flag_snan),
      .flag_imz  (flag_imz),
      .mul_req   (mul_req)
   );

   fmsr_expnorm #(
      .EXP_W   (EXP_W),
      .PROD_W  (PROD_W),
      .NORM_EN (NORM_EN)
   ) u_expnorm (
      .a_exp       (a_exp),
      .b_exp       (b_exp),
      .prod_sig    (prod_sig),
      .sticky_in   (sticky_in),
      .exp_sum     (exp_sum),
      .norm_exp    (norm_exp),
      .norm_sig    (norm_sig),
      .norm_sticky (norm_sticky)
   );

endmodule

// File: rtl/fmsr_chk.sv
module fmsr_chk #(
   parameter int EXP_W   = 11,
   parameter int PROD_W  = 48,
   parameter bit NORM_EN = 1'b1
) (
   input logic [2:0]              a_cls,
   input logic [2:0]              b_cls,
   input logic [PROD_W-1:0]       prod_sig,
   input logic [2:0]              res_cls,
   input logic                    res_sign,
   input logic [1:0]              res_src,
   input logic                    flag_snan,
   input logic                    flag_imz,
   input logic                    mul_req,
   input logic signed [EXP_W:0]   exp_sum,
   input logic signed [EXP_W:0]   norm_exp,
   input logic [PROD_W-1:0]       norm_sig
);

   logic any_nan;
   logic any_snan;
   logic signed [EXP_W:0] exp_step;

   assign any_nan  = (a_cls == 3'd3) || (a_cls == 3'd4) ||
                     (b_cls == 3'd3) || (b_cls == 3'd4);
   assign any_snan = (a_cls == 3'd4) || (b_cls == 3'd4);
   assign exp_step = norm_exp - exp_sum;

   always_comb begin
      // R2: a NaN operand always yields a NaN result from an operand
      if (any_nan) begin
         assert_nan_result_R2: assert ((res_cls == 3'd3 || res_cls == 3'd4) &&
                                       (res_src == 2'd1 || res_src == 2'd2));
      end
      // R3: the signalling flag follows the operand classes
      assert_snan_flag_R3: assert (flag_snan == any_snan);
      // R4: infinity-times-zero flag only with a positive default NaN
      if (flag_imz) begin
         assert_imz_default_R4: assert (res_cls == 3'd3 && !res_sign &&
                                        res_src == 2'd3 && !any_nan);
      end
      // R7: multiply request goes with a number result from the multiplier
      assert_mul_req_R7: assert (mul_req == (res_cls == 3'd0 && res_src == 2'd0));
      // R9: the normalised exponent steps up by at most one
      assert_exp_step_R9: assert (exp_step == '0 || exp_step == 1);
      // R9: no top bit survives normalisation
      if (NORM_EN) begin
         assert_norm_top_R9: assert (norm_sig[PROD_W-1] == 1'b0 ||
                                     prod_sig[PROD_W-1] == 1'b0);
      end
   end

endmodule

bind fmul_special_resolver fmsr_chk #(
   .EXP_W   (EXP_W),
   .PROD_W  (PROD_W),
   .NORM_EN (NORM_EN)
) u_chk (
   .a_cls     (a_cls),
   .b_cls     (b_cls),
   .prod_sig  (prod_sig),
   .res_cls   (res_cls),
   .res_sign  (res_sign),
   .res_src   (res_src),
   .flag_snan (flag_snan),
   .flag_imz  (flag_imz),
   .mul_req   (mul_req),
   .exp_sum   (exp_sum),
   .norm_exp  (norm_exp),
   .norm_sig  (norm_sig)
);

// File: tb/sim_fmul_special_resolver.sv
`timescale 1ns/1ps
module sim_fmul_special_resolver;

   localparam int EXP_W  = 11;
   localparam int PROD_W = 48;

   localparam logic [2:0] NUM = 3'd0, ZRO = 3'd1, INF = 3'd2, QNN = 3'd3, SNN = 3'd4;
   localparam logic [1:0] S_MUL = 2'd0, S_A = 2'd1, S_B = 2'd2, S_DF = 2'd3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [2:0]              a_cls, b_cls;
   logic                    a_sign, b_sign;
   logic signed [EXP_W-1:0] a_exp, b_exp;
   logic [PROD_W-1:0]       prod_sig;
   logic                    sticky_in;
   logic [2:0]              res_cls;
   logic                    res_sign;
   logic [1:0]              res_src;
   logic                    flag_snan, flag_imz, mul_req;
   logic signed [EXP_W:0]   exp_sum, norm_exp;
   logic [PROD_W-1:0]       norm_sig;
   logic                    norm_sticky;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   fmul_special_resolver #(.EXP_W(EXP_W), .PROD_W(PROD_W), .NORM_EN(1'b1)) u0 (
      .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp),
      .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp),
      .prod_sig(prod_sig), .sticky_in(sticky_in),
      .res_cls(res_cls), .res_sign(res_sign), .res_src(res_src),
      .flag_snan(flag_snan), .flag_imz(flag_imz), .mul_req(mul_req),
      .exp_sum(exp_sum), .norm_exp(norm_exp),
      .norm_sig(norm_sig), .norm_sticky(norm_sticky)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Inputs change on the falling edge; outputs are read 2 ns later.
   task automatic apply(input logic [2:0] ac, input logic as_, input logic [2:0] bc,
                        input logic bs);
      @(negedge clk);
      a_cls = ac; a_sign = as_; b_cls = bc; b_sign = bs;
      #2;
   endtask

   task automatic expect_res(input string req, input logic [2:0] c, input logic s,
                             input logic [1:0] src, input logic fs, input logic fi,
                             input logic mr);
      check(req, "res_cls", 64'(res_cls), 64'(c));
      check(req, "res_sign", 64'(res_sign), 64'(s));
      check(req, "res_src", 64'(res_src), 64'(src));
      check(req, "flag_snan", 64'(flag_snan), 64'(fs));
      check(req, "flag_imz", 64'(flag_imz), 64'(fi));
      check(req, "mul_req", 64'(mul_req), 64'(mr));
   endtask

   task automatic t_idle;
      // All-zero inputs read as number times number, zero exponents (R1, R7)
      #2;
      expect_res("R1", NUM, 1'b0, S_MUL, 1'b0, 1'b0, 1'b1);
      check("R8", "exp_sum", 64'(exp_sum), 64'd0);
   endtask

   task automatic t_nan;
      apply(QNN, 1'b1, NUM, 1'b0);
      expect_res("R2", QNN, 1'b1, S_A, 1'b0, 1'b0, 1'b0);
      apply(ZRO, 1'b0, QNN, 1'b1);
      expect_res("R2", QNN, 1'b1, S_B, 1'b0, 1'b0, 1'b0);
      apply(QNN, 1'b0, SNN, 1'b1);
      expect_res("R2", SNN, 1'b1, S_B, 1'b1, 1'b0, 1'b0);
      apply(SNN, 1'b1, QNN, 1'b0);
      expect_res("R2", SNN, 1'b1, S_A, 1'b1, 1'b0, 1'b0);
      apply(QNN, 1'b0, QNN, 1'b1);
      expect_res("R2", QNN, 1'b1, S_B, 1'b0, 1'b0, 1'b0);
      apply(SNN, 1'b1, INF, 1'b0);
      expect_res("R3", SNN, 1'b1, S_A, 1'b1, 1'b0, 1'b0);
      apply(ZRO, 1'b0, SNN, 1'b0);
      expect_res("R3", SNN, 1'b0, S_B, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_inf_zero;
      apply(INF, 1'b1, ZRO, 1'b1);
      expect_res("R4", QNN, 1'b0, S_DF, 1'b0, 1'b1, 1'b0);
      apply(ZRO, 1'b0, INF, 1'b1);
      expect_res("R4", QNN, 1'b0, S_DF, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_inf;
      for (int s = 0; s < 4; s++) begin
         apply(INF, s[0], NUM, s[1]);
         expect_res("R5", INF, s[0] ^ s[1], S_A, 1'b0, 1'b0, 1'b0);
         apply(NUM, s[0], INF, s[1]);
         expect_res("R5", INF, s[0] ^ s[1], S_B, 1'b0, 1'b0, 1'b0);
      end
      apply(INF, 1'b1, INF, 1'b1);
      expect_res("R5", INF, 1'b0, S_B, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_zero;
      apply(ZRO, 1'b1, NUM, 1'b0);
      expect_res("R6", ZRO, 1'b1, S_A, 1'b0, 1'b0, 1'b0);
      apply(NUM, 1'b1, ZRO, 1'b1);
      expect_res("R6", ZRO, 1'b0, S_B, 1'b0, 1'b0, 1'b0);
      apply(ZRO, 1'b0, ZRO, 1'b1);
      expect_res("R6", ZRO, 1'b1, S_A, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_num;
      for (int s = 0; s < 4; s++) begin
         apply(NUM, s[0], NUM, s[1]);
         expect_res("R7", NUM, s[0] ^ s[1], S_MUL, 1'b0, 1'b0, 1'b1);
      end
   endtask

   task automatic t_exp;
      int pairs [5][2] = '{'{1023, 1023}, '{-1024, -1024}, '{-1024, 1023},
                           '{300, -77}, '{-5, -9}};
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         a_exp = EXP_W'(pairs[i][0]);
         b_exp = EXP_W'(pairs[i][1]);
         prod_sig = 48'h4000_0000_0000;
         sticky_in = 1'b0;
         #2;
         check("R8", "exp_sum", 64'(exp_sum), 64'((EXP_W+1)'(pairs[i][0] + pairs[i][1])));
         check("R10", "norm_exp", 64'(norm_exp), 64'((EXP_W+1)'(pairs[i][0] + pairs[i][1])));
      end
   endtask

   task automatic t_norm;
      @(negedge clk);
      a_exp = 11'sd1023; b_exp = 11'sd1023;
      prod_sig = 48'h8000_0000_0001; sticky_in = 1'b0;
      #2;
      check("R9", "norm_sig", 64'(norm_sig), 64'h4000_0000_0000);
      check("R9", "norm_sticky", 64'(norm_sticky), 64'd1);
      check("R9", "norm_exp", 64'(norm_exp), 64'(12'sd2047));
      @(negedge clk);
      a_exp = -11'sd20; b_exp = 11'sd3;
      prod_sig = 48'hC000_0000_0002; sticky_in = 1'b1;
      #2;
      check("R9", "norm_sig", 64'(norm_sig), 64'h6000_0000_0001);
      check("R9", "norm_sticky", 64'(norm_sticky), 64'd1);
      check("R9", "norm_exp", 64'(norm_exp), 64'(-12'sd16));
      @(negedge clk);
      prod_sig = 48'hC000_0000_0002; sticky_in = 1'b0;
      #2;
      check("R9", "norm_sticky", 64'(norm_sticky), 64'd0);
      @(negedge clk);
      prod_sig = 48'h7FFF_FFFF_FFFF; sticky_in = 1'b1;
      #2;
      check("R10", "norm_sig", 64'(norm_sig), 64'h7FFF_FFFF_FFFF);
      check("R10", "norm_sticky", 64'(norm_sticky), 64'd1);
      check("R10", "norm_exp", 64'(norm_exp), 64'(-12'sd17));
      @(negedge clk);
      sticky_in = 1'b0;
      #2;
      check("R10", "norm_sticky", 64'(norm_sticky), 64'd0);
   endtask

   initial begin
      a_cls = NUM; a_sign = 1'b0; a_exp = '0;
      b_cls = NUM; b_sign = 1'b0; b_exp = '0;
      prod_sig = '0; sticky_in = 1'b0;
      t_idle();
      t_nan();
      t_inf_zero();
      t_inf();
      t_zero();
      t_num();
      t_exp();
      t_norm();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule